// File: doc/BRIEF.md
# Switch Table Access Engine

A host-facing command engine that gives a CPU indirect access to three internal switch tables: a hashed L2 forwarding memory of four-slot buckets, a small L2 associative (CAM) table, and a per-instance spanning-tree port-state table. The host reaches the tables through a small register window. Each of two command channels has one command register and a set of 32-bit staging data registers. The L2 channel carries three-word entries. The auxiliary channel carries two-word spanning-tree entries.

For a write, the host first fills the staging registers and then writes a command word. That word holds an execute flag, a direction flag, a two-bit table selector and an entry index. The execute flag reads back as 1 while the access runs and clears by itself. For a read, the staging registers hold the entry from the cycle in which execute clears. A command written while its channel is still busy is dropped, and a sticky error flag is raised. Table selectors with no table behind them complete without touching any memory and return zeros. The two channels run independently.

Register window (4-bit address): 0 L2 command, 1..3 L2 data words 0..2, 4 auxiliary command, 5..6 auxiliary data words 0..1, 7 status. All other addresses read as zero.

Top module: `tbl_access_engine`

## Requirements
- R1: After reset, every register in the window reads zero, so both execute flags are clear.
- R2: The L2 command word has these fields: bit 16 execute, bit 15 direction (1 read, 0 write), bits 14:13 table selector, bits 12:0 index. A command write with bit 16 clear starts nothing and changes no table. The command register reads back the last accepted direction, selector and index, with bit 16 showing the live execute flag.
- R3: After the clock edge that accepts a command, the execute flag reads 1 for exactly two cycles and then reads 0. In the cycle it reads 0, a read command's data words are already in the staging registers.
- R4: Selector 00 addresses the hashed L2 memory. The index is {hash, slot} with the 2-bit slot in bits 1:0, so each hash bucket holds four independent entries. Only the low L2_HASH_W+2 index bits are decoded. A write followed by a read returns all three words.
- R5: Selector 01 addresses the 64-entry L2 CAM through index bits 5:0. It is separate storage from the hashed memory: the same index number can hold different data in the two tables.
- R6: Status bit 2 is updated at the end of every L2 read. It is 1 when bits 31:17 of the returned word 0 are not all zero (a valid entry) and 0 otherwise.
- R7: The auxiliary command word has these fields: bit 15 execute, bit 14 direction (1 read), bits 13:12 selector, bits 11:0 index. Selector 10 addresses the spanning-tree table of two-word entries, and it follows the same two-cycle timing as R3.
- R8: A command write while the channel is busy is ignored: no access happens and the readback fields stay unchanged. It sets the channel's error flag (status bit 0 for L2, bit 1 for auxiliary). The next accepted command on that channel clears the flag.
- R9: A write to an unimplemented selector (L2 10/11, auxiliary 00/01/11) completes with the normal timing and modifies no table. A read from one returns all-zero data words.
- R10: The two channels operate concurrently: a command on one channel can start while the other is busy, and both complete correctly.
- R11: The staging registers keep the values the host wrote. A write command stores those values and leaves the staging registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
Entries are written and then read back from two slots of one hash bucket, from the CAM and from the hashed memory at the same index number, and from the spanning-tree table. This separates the slot decoding, the table selection and the word ordering. Entries that differ only in bits 31:17 of word 0 tell the validity test apart from a test on the whole word. Back-to-back command writes on one channel, alternated with back-to-back writes across the two channels, show that a busy-channel command is dropped while the other channel is not blocked. Commands with execute clear or with an unused selector are each followed by read-backs of the entries they could have corrupted.

// File: rtl/tae_pkg.sv
package tae_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_LATCH  = 2'd2
  } phase_t;

  localparam logic [1:0] TT_HASH = 2'b00;
  localparam logic [1:0] TT_CAM  = 2'b01;
  localparam logic [1:0] TT_STP  = 2'b10;

  localparam int L2_IDX_W  = 13;
  localparam int AUX_IDX_W = 12;
  localparam int L2_WORDS  = 3;
  localparam int AUX_WORDS = 2;
  localparam int CAM_AW    = 6;

  localparam logic [3:0] RA_L2_CMD   = 4'd0;
  localparam logic [3:0] RA_L2_DAT0  = 4'd1;
  localparam logic [3:0] RA_AUX_CMD  = 4'd4;
  localparam logic [3:0] RA_AUX_DAT0 = 4'd5;
  localparam logic [3:0] RA_STATUS   = 4'd7;

  // An L2 entry counts as valid when any of word0[31:17] is set.
  function automatic logic entry_live(input logic [31:0] w0);
    return |w0[31:17];
  endfunction

endpackage

// File: rtl/tae_table_store.sv
module tae_table_store #(
  parameter int         NWORDS = 3,
  parameter int         AW     = 6,
  parameter int         IDX_W  = 13,
  parameter logic [1:0] CODE   = 2'b00
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic                   we,
  input  logic [1:0]             ttype,
  input  logic [IDX_W-1:0]       idx,
  input  logic [NWORDS*32-1:0]   wdata,
  output logic [NWORDS*32-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = NWORDS * 32;

  logic [DW-1:0] mem [DEPTH];
  logic          sel;
  logic [AW-1:0] addr;
  logic          wr_evt;
  logic          rd_evt;
  logic          unused_idx;

  assign sel        = (ttype == CODE);
  assign addr       = idx[AW-1:0];
  assign wr_evt     = en && we && sel;
  assign rd_evt     = en && !we;
  assign unused_idx = ^idx;

  always_ff @(posedge clk) begin
    if (wr_evt) mem[addr] <= wdata;
    if (rd_evt) rdata <= sel ? mem[addr] : '0;
  end

endmodule

// File: rtl/tae_cmd_engine.sv
module tae_cmd_engine
  import tae_pkg::*;
#(
  parameter int EXEC_BIT = 16,
  parameter int DIR_BIT  = 15,
  parameter int TYPE_LSB = 13,
  parameter int IDX_W    = 13,
  parameter int NWORDS   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [NWORDS-1:0]     dat_wr,
  input  logic [31:0]           wdata,
  input  logic [NWORDS*32-1:0]  rsp_data,
  output logic [31:0]           cmd_word,
  output logic [NWORDS*32-1:0]  dat_q,
  output logic                  err_q,
  output logic                  busy,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [1:0]            mem_type,
  output logic [IDX_W-1:0]      mem_idx,
  output logic [NWORDS*32-1:0]  mem_wdata,
  output logic                  rd_done
);
  phase_t           ph_q;
  logic             dir_q;
  logic [1:0]       type_q;
  logic [IDX_W-1:0] idx_q;
  logic             accept;
  logic             reject;

  assign busy   = (ph_q != PH_IDLE);
  assign accept = cmd_wr && !busy && wdata[EXEC_BIT];
  assign reject = cmd_wr && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      dir_q  <= 1'b0;
      type_q <= '0;
      idx_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE:   if (accept) ph_q <= PH_ACCESS;
        PH_ACCESS: ph_q <= PH_LATCH;
        default:   ph_q <= PH_IDLE;
      endcase
      if (accept) begin
        dir_q  <= wdata[DIR_BIT];
        type_q <= wdata[TYPE_LSB +: 2];
        idx_q  <= wdata[IDX_W-1:0];
        err_q  <= 1'b0;
      end else if (reject) begin
        err_q  <= 1'b1;
      end
    end
  end

  assign rd_done = (ph_q == PH_LATCH) && dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (rd_done)        dat_q[w*32 +: 32] <= rsp_data[w*32 +: 32];
        else if (dat_wr[w]) dat_q[w*32 +: 32] <= wdata;
      end
    end
  end

  assign mem_en    = (ph_q == PH_ACCESS);
  assign mem_we    = mem_en && !dir_q;
  assign mem_type  = type_q;
  assign mem_idx   = idx_q;
  assign mem_wdata = dat_q;

  always_comb begin
    cmd_word                  = '0;
    cmd_word[IDX_W-1:0]       = idx_q;
    cmd_word[TYPE_LSB +: 2]   = type_q;
    cmd_word[DIR_BIT]         = dir_q;
    cmd_word[EXEC_BIT]        = busy;
  end

  AST_EXEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy ##1 busy); // R3
  AST_EXEC_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |=> !busy); // R3
  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) mem_en |=> !mem_en); // R3
  AST_BUSY_CMD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) reject |=> err_q); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_q) |-> $past(reject)); // R8
  AST_BUSY_FIELDS_KEEP: assert property (@(posedge clk) disable iff (!rst_n) reject |=> $stable(idx_q) && $stable(type_q)); // R8

endmodule

// File: rtl/tbl_access_engine.sv
module tbl_access_engine
  import tae_pkg::*;
#(
  parameter int L2_HASH_W = 6,
  parameter int STP_AW    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int SRAM_AW = L2_HASH_W + 2;
  localparam int L2_DW   = L2_WORDS * 32;
  localparam int AUX_DW  = AUX_WORDS * 32;

  logic                 l2_cmd_wr, aux_cmd_wr;
  logic [L2_WORDS-1:0]  l2_dat_wr;
  logic [AUX_WORDS-1:0] aux_dat_wr;

  always_comb begin
    l2_cmd_wr  = reg_wr && (reg_addr == RA_L2_CMD);
    aux_cmd_wr = reg_wr && (reg_addr == RA_AUX_CMD);
    for (int k = 0; k < L2_WORDS; k++)
      l2_dat_wr[k] = reg_wr && (reg_addr == 4'(RA_L2_DAT0 + k));
    for (int k = 0; k < AUX_WORDS; k++)
      aux_dat_wr[k] = reg_wr && (reg_addr == 4'(RA_AUX_DAT0 + k));
  end

  // L2 channel
  logic [31:0]         l2_cmd_word;
  logic [L2_DW-1:0]    l2_dat, l2_rsp, l2_mem_wdata, sram_rd, cam_rd;
  logic                l2_err, l2_busy, l2_en, l2_we, l2_rd_done;
  logic [1:0]          l2_type;
  logic [L2_IDX_W-1:0] l2_idx;

  tae_cmd_engine #(
    .EXEC_BIT(16), .DIR_BIT(15), .TYPE_LSB(13), .IDX_W(L2_IDX_W), .NWORDS(L2_WORDS)
  ) l2_eng_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(l2_cmd_wr), .dat_wr(l2_dat_wr), .wdata(reg_wdata),
    .rsp_data(l2_rsp), .cmd_word(l2_cmd_word), .dat_q(l2_dat), .err_q(l2_err),
    .busy(l2_busy), .mem_en(l2_en), .mem_we(l2_we), .mem_type(l2_type), .mem_idx(l2_idx),
    .mem_wdata(l2_mem_wdata), .rd_done(l2_rd_done)
  );

  tae_table_store #(.NWORDS(L2_WORDS), .AW(SRAM_AW), .IDX_W(L2_IDX_W), .CODE(TT_HASH)) sram_i (
    .clk(clk), .en(l2_en), .we(l2_we), .ttype(l2_type), .idx(l2_idx),
    .wdata(l2_mem_wdata), .rdata(sram_rd)
  );

  tae_table_store #(.NWORDS(L2_WORDS), .AW(CAM_AW), .IDX_W(L2_IDX_W), .CODE(TT_CAM)) cam_i (
    .clk(clk), .en(l2_en), .we(l2_we), .ttype(l2_type), .idx(l2_idx),
    .wdata(l2_mem_wdata), .rdata(cam_rd)
  );

  assign l2_rsp = sram_rd | cam_rd;

  // Auxiliary channel (spanning-tree state)
  logic [31:0]          aux_cmd_word;
  logic [AUX_DW-1:0]    aux_dat, aux_rsp, aux_mem_wdata;
  logic                 aux_err, aux_busy, aux_en, aux_we, aux_rd_done;
  logic [1:0]           aux_type;
  logic [AUX_IDX_W-1:0] aux_idx;

  tae_cmd_engine #(
    .EXEC_BIT(15), .DIR_BIT(14), .TYPE_LSB(12), .IDX_W(AUX_IDX_W), .NWORDS(AUX_WORDS)
  ) aux_eng_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(aux_cmd_wr), .dat_wr(aux_dat_wr), .wdata(reg_wdata),
    .rsp_data(aux_rsp), .cmd_word(aux_cmd_word), .dat_q(aux_dat), .err_q(aux_err),
    .busy(aux_busy), .mem_en(aux_en), .mem_we(aux_we), .mem_type(aux_type), .mem_idx(aux_idx),
    .mem_wdata(aux_mem_wdata), .rd_done(aux_rd_done)
  );

  tae_table_store #(.NWORDS(AUX_WORDS), .AW(STP_AW), .IDX_W(AUX_IDX_W), .CODE(TT_STP)) stp_i (
    .clk(clk), .en(aux_en), .we(aux_we), .ttype(aux_type), .idx(aux_idx),
    .wdata(aux_mem_wdata), .rdata(aux_rsp)
  );

  // Status: valid flag of last L2 read entry
  logic l2_live_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          l2_live_q <= 1'b0;
    else if (l2_rd_done) l2_live_q <= entry_live(l2_rsp[31:0]);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_L2_CMD)  reg_rdata = l2_cmd_word;
    if (reg_addr == RA_AUX_CMD) reg_rdata = aux_cmd_word;
    if (reg_addr == RA_STATUS)  reg_rdata = {29'd0, l2_live_q, aux_err, l2_err};
    for (int k = 0; k < L2_WORDS; k++)
      if (reg_addr == 4'(RA_L2_DAT0 + k)) reg_rdata = l2_dat[k*32 +: 32];
    for (int k = 0; k < AUX_WORDS; k++)
      if (reg_addr == 4'(RA_AUX_DAT0 + k)) reg_rdata = aux_dat[k*32 +: 32];
  end

  AST_LIVE_FOLLOWS_WORD0: assert property (@(posedge clk) disable iff (!rst_n) l2_rd_done |=> (l2_live_q == (l2_dat[31:17] != 15'd0))); // R6
  AST_AUX_IDLE_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!aux_busy && !aux_cmd_wr) |=> !aux_busy); // R7
  AST_L2_IDLE_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!l2_busy && !l2_cmd_wr) |=> !l2_busy); // R2

endmodule

// File: tb/tbl_access_engine_tb_top.sv
module tbl_access_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  tbl_access_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  localparam logic [3:0] A_L2C = 4'd0, A_L2D0 = 4'd1, A_L2D1 = 4'd2, A_L2D2 = 4'd3;
  localparam logic [3:0] A_AXC = 4'd4, A_AXD0 = 4'd5, A_AXD1 = 4'd6, A_ST = 4'd7;

  function automatic logic [31:0] l2c(input bit rd, input logic [1:0] t, input logic [12:0] i);
    return (32'd1 << 16) | (32'(rd) << 15) | (32'(t) << 13) | 32'(i);
  endfunction
  function automatic logic [31:0] axc(input bit rd, input logic [1:0] t, input logic [11:0] i);
    return (32'd1 << 15) | (32'(rd) << 14) | (32'(t) << 12) | 32'(i);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run(input logic [3:0] a, input logic [31:0] cmd);
    wr(a, cmd);
    step(2);
  endtask

  task automatic l2_put(input logic [1:0] t, input logic [12:0] i,
                        input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    wr(A_L2D0, w0); wr(A_L2D1, w1); wr(A_L2D2, w2);
    run(A_L2C, l2c(1'b0, t, i));
  endtask

  task automatic l2_get_check(input string tag, input logic [1:0] t, input logic [12:0] i,
                              input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    logic [31:0] v;
    run(A_L2C, l2c(1'b1, t, i));
    rd(A_L2D0, v); check({tag, " w0"}, v, w0);
    rd(A_L2D1, v); check({tag, " w1"}, v, w1);
    rd(A_L2D2, v); check({tag, " w2"}, v, w2);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), v);
      check($sformatf("R1 reset reg %0d", a), v, 32'd0);
    end
  endtask

  task automatic t_sram_timing;
    logic [31:0] v;
    wr(A_L2D0, 32'hAAAA_0001); wr(A_L2D1, 32'hAAAA_0002); wr(A_L2D2, 32'hAAAA_0003);
    wr(A_L2C, l2c(1'b0, 2'b00, 13'd23));  // hash 5, slot 3
    rd(A_L2C, v); check("R3 exec set after accept", v, l2c(1'b0, 2'b00, 13'd23));
    step(1);
    rd(A_L2C, v); check("R3 exec still set second cycle", v[16], 1'b1);
    step(1);
    rd(A_L2C, v); check("R3 exec cleared, R2 readback", v, 32'h0000_0017);
    rd(A_L2D1, v); check("R11 staging kept after write cmd", v, 32'hAAAA_0002);
    l2_put(2'b00, 13'd22, 32'hBBBB_0001, 32'hBBBB_0002, 32'hBBBB_0003);  // hash 5, slot 2
    wr(A_L2D0, 32'd0); wr(A_L2D1, 32'd0); wr(A_L2D2, 32'd0);
    wr(A_L2C, l2c(1'b1, 2'b00, 13'd23));
    step(1);
    rd(A_L2D0, v); check("R3 no data before completion", v, 32'd0);
    step(1);
    rd(A_L2D0, v); check("R3 data on clearing cycle", v, 32'hAAAA_0001);
    rd(A_L2C, v);  check("R3 read exec clear", v[16], 1'b0);
    l2_get_check("R4 slot3", 2'b00, 13'd23, 32'hAAAA_0001, 32'hAAAA_0002, 32'hAAAA_0003);
    l2_get_check("R4 slot2", 2'b00, 13'd22, 32'hBBBB_0001, 32'hBBBB_0002, 32'hBBBB_0003);
    l2_get_check("R4 aliased index", 2'b00, 13'h1000 | 13'd22, 32'hBBBB_0001, 32'hBBBB_0002, 32'hBBBB_0003);
  endtask

  task automatic t_no_exec;
    logic [31:0] v;
    wr(A_L2D0, 32'h1111_1111); wr(A_L2D1, 32'h1111_1111); wr(A_L2D2, 32'h1111_1111);
    wr(A_L2C, l2c(1'b0, 2'b00, 13'd22) & ~32'h0001_0000);
    rd(A_L2C, v); check("R2 exec clear starts nothing", v[16], 1'b0);
    step(2);
    l2_get_check("R2 table untouched", 2'b00, 13'd22, 32'hBBBB_0001, 32'hBBBB_0002, 32'hBBBB_0003);
  endtask

  task automatic t_cam;
    l2_put(2'b01, 13'd5, 32'hC0C0_0005, 32'hC1C1_0005, 32'hC2C2_0005);
    l2_put(2'b00, 13'd5, 32'hD0D0_0005, 32'hD1D1_0005, 32'hD2D2_0005);
    l2_put(2'b01, 13'd63, 32'hC0C0_003F, 32'h0, 32'h1);
    l2_get_check("R5 cam 5", 2'b01, 13'd5, 32'hC0C0_0005, 32'hC1C1_0005, 32'hC2C2_0005);
    l2_get_check("R5 sram 5", 2'b00, 13'd5, 32'hD0D0_0005, 32'hD1D1_0005, 32'hD2D2_0005);
    l2_get_check("R5 cam 63", 2'b01, 13'd63, 32'hC0C0_003F, 32'h0, 32'h1);
  endtask

  task automatic t_valid;
    logic [31:0] v;
    l2_put(2'b00, 13'd40, 32'h0001_FFFF, 32'h5, 32'h6);
    l2_put(2'b00, 13'd41, 32'h0002_0000, 32'h7, 32'h8);
    run(A_L2C, l2c(1'b1, 2'b00, 13'd41));
    rd(A_ST, v); check("R6 valid entry flag", v[2], 1'b1);
    run(A_L2C, l2c(1'b1, 2'b00, 13'd40));
    rd(A_ST, v); check("R6 invalid entry flag", v[2], 1'b0);
    run(A_L2C, l2c(1'b1, 2'b00, 13'd41));
    rd(A_ST, v); check("R6 valid entry flag again", v[2], 1'b1);
  endtask

  task automatic t_stp;
    logic [31:0] v;
    wr(A_AXD0, 32'h5757_0009); wr(A_AXD1, 32'h7575_0009);
    wr(A_AXC, axc(1'b0, 2'b10, 12'd9));
    rd(A_AXC, v); check("R7 aux exec set", v, axc(1'b0, 2'b10, 12'd9));
    step(1);
    rd(A_AXC, v); check("R7 aux exec second cycle", v[15], 1'b1);
    step(1);
    rd(A_AXC, v); check("R7 aux exec cleared", v[15], 1'b0);
    wr(A_AXD0, 32'd0); wr(A_AXD1, 32'd0);
    run(A_AXC, axc(1'b1, 2'b10, 12'd9));
    rd(A_AXD0, v); check("R7 stp w0", v, 32'h5757_0009);
    rd(A_AXD1, v); check("R7 stp w1", v, 32'h7575_0009);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    l2_put(2'b00, 13'd50, 32'hE0E0_0032, 32'hE1, 32'hE2);
    wr(A_L2D0, 32'h9999_9999); wr(A_L2D1, 32'h9); wr(A_L2D2, 32'h9);
    wr(A_L2C, l2c(1'b1, 2'b01, 13'd5));
    wr(A_L2C, l2c(1'b0, 2'b00, 13'd50));  // arrives while busy
    rd(A_ST, v);  check("R8 l2 error set", v[0], 1'b1);
    rd(A_L2C, v); check("R8 fields kept", v, l2c(1'b1, 2'b01, 13'd5));
    step(1);
    rd(A_L2D0, v); check("R8 first cmd completed", v, 32'hC0C0_0005);
    l2_get_check("R8 dropped write had no effect", 2'b00, 13'd50, 32'hE0E0_0032, 32'hE1, 32'hE2);
    rd(A_ST, v); check("R8 error cleared by accept", v[0], 1'b0);
    wr(A_AXC, axc(1'b1, 2'b10, 12'd9));
    wr(A_AXC, axc(1'b1, 2'b10, 12'd9));
    rd(A_ST, v); check("R8 aux error set", v[1:0], 2'b10);
    step(1);
  endtask

  task automatic t_unimpl;
    logic [31:0] v;
    l2_put(2'b11, 13'd50, 32'hF, 32'hF, 32'hF);
    l2_put(2'b10, 13'd50, 32'hF, 32'hF, 32'hF);
    l2_get_check("R9 sram untouched", 2'b00, 13'd50, 32'hE0E0_0032, 32'hE1, 32'hE2);
    l2_get_check("R9 cam untouched", 2'b01, 13'd5, 32'hC0C0_0005, 32'hC1C1_0005, 32'hC2C2_0005);
    l2_get_check("R9 l2 unimpl read zero", 2'b10, 13'd50, 32'h0, 32'h0, 32'h0);
    wr(A_AXD0, 32'h1234_5678); wr(A_AXD1, 32'h1234_5678);
    run(A_AXC, axc(1'b0, 2'b00, 12'd9));
    run(A_AXC, axc(1'b0, 2'b11, 12'd9));
    run(A_AXC, axc(1'b1, 2'b10, 12'd9));
    rd(A_AXD0, v); check("R9 stp untouched w0", v, 32'h5757_0009);
    rd(A_AXD1, v); check("R9 stp untouched w1", v, 32'h7575_0009);
    run(A_AXC, axc(1'b1, 2'b01, 12'd9));
    rd(A_AXD0, v); check("R9 aux unimpl read zero", v, 32'h0);
  endtask

  task automatic t_concurrent;
    logic [31:0] v;
    wr(A_L2C, l2c(1'b1, 2'b00, 13'd23));
    wr(A_AXC, axc(1'b1, 2'b10, 12'd9));
    rd(A_ST, v); check("R10 no error across channels", v[1:0], 2'b00);
    step(1);
    rd(A_L2D2, v); check("R10 l2 result", v, 32'hAAAA_0003);
    step(1);
    rd(A_AXD1, v); check("R10 aux result", v, 32'h7575_0009);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_sram_timing();
    t_no_exec();
    t_cam();
    t_valid();
    t_stp();
    t_reject();
    t_unimpl();
    t_concurrent();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule